// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block serialises bytes onto a single output line using the asynchronous start/stop framing. A host writes a word into a one-entry holding register. When the shifter behind it is idle, the word moves straight into the shift register, and the holding register is free again for the next word. Frames therefore follow one another without a gap, provided the host refills the holding register before the current frame ends. Two flags tell the host what it may do next. One reports that the holding register can take a new word. The other reports that the line has finished sending everything.

A programmable divider sets the bit period. A width bit chooses whether the divider uses an 8-bit or a 16-bit value, and a speed bit chooses a prescale of 16 or 64. Three configuration inputs shape each frame: the word length (7, 8 or 9 bits), an optional parity bit, and one or two stop bits. The transmitter runs only while the module enable and the transmit enable are both high and the synchronous-mode select is low. Dropping any of these abandons the current frame and clears both registers.

Top module: `ser_tx_dbuf`

## Requirements
- R1: `txLine` sits at 1 whenever no frame is in progress. Each frame opens with a single 0 start bit and closes with stop bits at 1: one stop bit when `twoStop`=0, two when `twoStop`=1.
- R2: `lenSel` sets the number of data bits: 0 gives 7, 1 gives 8, 2 gives 9, 3 gives 8. The data bits follow the start bit, bit 0 of the written word first. Word bits above the selected length are not sent.
- R3: When `parityEn`=1, one extra bit follows the last data bit. It is 1 exactly when the transmitted data bits contain an odd number of ones. When `parityEn`=0, no such bit is sent.
- R4: Take a write accepted while the holding register is empty and the shifter is idle, captured at clock edge E. `holdEmpty` reads 0 after E. After E+1 it reads 1 again and `shiftEmpty` reads 0. The start bit begins on the first baud tick after that, which is no more than one bit period later.
- R5: `shiftEmpty` falls when the shift register is loaded. It rises only at the clock edge that ends the last stop bit. If the holding register is full at that edge, its word is loaded at the same edge instead: the next start bit follows with no idle time, `shiftEmpty` stays 0, and `holdEmpty` rises.
- R6: The transmitter is active only when `blockEn`=1, `txEn`=1 and `syncSel`=0. While inactive, `holdEmpty` is 0, writes are dropped, and the line returns to 1 with `shiftEmpty`=1 one clock later, abandoning any frame. `holdEmpty` reads 1 as soon as the transmitter becomes active with nothing held.
- R7: One bit lasts 16×(N+1) clocks when `hiSpeed`=1 and 64×(N+1) clocks when `hiSpeed`=0. N is `divisor[7:0]` when `wideDiv`=0 and the full `divisor[15:0]` when `wideDiv`=1.
- R8: A write while the holding register is full is ignored. `holdEmpty` stays 0, and the held word is the one that gets sent.
- R9: While `rstN` is low and after its release, `txLine` is 1 and `shiftEmpty` is 1 until a word is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| blockEn | input | 1 | Module enable |
| txEn | input | 1 | Transmit enable |
| syncSel | input | 1 | Synchronous-mode select; must be 0 to transmit |
| hiSpeed | input | 1 | 1: prescale 16, 0: prescale 64 |
| wideDiv | input | 1 | 1: 16-bit divisor, 0: low 8 bits only |
| divisor | input | 16 | Baud divisor N |
| lenSel | input | 2 | Data length select (see R2) |
| parityEn | input | 1 | Append the odd-count parity bit |
| twoStop | input | 1 | Send two stop bits |
| wrEn | input | 1 | Write strobe for the holding register |
| wrData | input | 9 | Word to transmit |
| holdEmpty | output | 1 | Holding register can accept a word |
| shiftEmpty | output | 1 | Shifter idle, last stop bit finished |
| txLine | output | 1 | Serial output |

## Verification
Each result has a fixed due cycle. The flag response to a write is due one edge and then two edges after the capturing edge. The start bit is due no more than one bit period after the load. After that, bit i of a frame holds from i periods to i+1 periods after the start edge, and `shiftEmpty` must rise exactly at the end of the frame. The bench finds the start bit by polling at falling clock edges. It then samples each bit at its midpoint, and it samples `shiftEmpty` one cycle before and exactly at the computed frame end, so an error of even one clock in the period shows up. Back-to-back frames and the enable inputs are checked the same way, one cycle after each stimulus.

// File: rtl/ser_tx_pkg.sv
`timescale 1ns/1ps
package ser_tx_pkg;

  localparam int MAX_DATA_BITS = 9;
  localparam int BIT_CNT_W     = $clog2(MAX_DATA_BITS + 1);

  // Strobes issued by the control FSM to the datapath, at most one line action per cycle
  typedef struct packed {
    logic loadShift;   // hold -> shift, latch parity
    logic sendStart;   // drive start bit
    logic sendData;    // drive shift[0], shift right
    logic sendParity;  // drive parity bit
    logic sendStop;    // drive stop level
    logic goIdle;      // frame over, nothing held
  } txStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_START, ST_DATA, ST_PARITY, ST_STOP1, ST_STOP2
  } txState_t;

  // Word length encoding: 0 -> 7, 1 -> 8, 2 -> 9, 3 -> 8
  function automatic logic [BIT_CNT_W-1:0] bitsForLen(input logic [1:0] sel);
    case (sel)
      2'd0:    bitsForLen = BIT_CNT_W'(7);
      2'd2:    bitsForLen = BIT_CNT_W'(9);
      default: bitsForLen = BIT_CNT_W'(8);
    endcase
  endfunction

endpackage

// File: rtl/ser_tx_baud.sv
`timescale 1ns/1ps
module ser_tx_baud #(
  parameter int DIV_W      = 16,
  parameter int NARROW_W   = 8,
  parameter int FAST_SHIFT = 4,
  parameter int SLOW_SHIFT = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic             hiSpeed,
  input  logic             wideDiv,
  input  logic [DIV_W-1:0] divisor,
  output logic             baudTick
);

  localparam int CNT_W = DIV_W + SLOW_SHIFT;

  logic [DIV_W-1:0] divSel;
  logic [CNT_W-1:0] nPlusOne;
  logic [CNT_W-1:0] periodLast;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    divSel = wideDiv ? divisor : {{(DIV_W-NARROW_W){1'b0}}, divisor[NARROW_W-1:0]};
    nPlusOne = CNT_W'(divSel) + CNT_W'(1);
    // modulo arithmetic makes the largest divisor wrap to all ones, which is still correct
    if (hiSpeed) periodLast = (nPlusOne << FAST_SHIFT) - CNT_W'(1);
    else         periodLast = (nPlusOne << SLOW_SHIFT) - CNT_W'(1);
    // >= so a shorter period picked while idle cannot leave the counter stranded
    baudTick = run && (cnt >= periodLast);
  end

  always_ff @(posedge clk) begin
    if (!rstN || !run) cnt <= '0;
    else if (baudTick) cnt <= '0;
    else               cnt <= cnt + CNT_W'(1);
  end

endmodule

// File: rtl/ser_tx_ctrl.sv
`timescale 1ns/1ps
module ser_tx_ctrl
  import ser_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       active,
  input  logic       baudTick,
  input  logic       holdFull,
  input  logic [1:0] lenSel,
  input  logic       parityEn,
  input  logic       twoStop,
  output txStrobes_t strobes,
  output logic       shiftIdle
);

  txState_t state, stateNext;
  logic [BIT_CNT_W-1:0] bitCnt, bitCntNext;

  always_comb begin
    strobes    = '0;
    stateNext  = state;
    bitCntNext = bitCnt;
    if (active) begin
      case (state)
        ST_IDLE: begin
          if (holdFull) begin
            strobes.loadShift = 1'b1;
            stateNext = ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (baudTick) begin
            strobes.sendStart = 1'b1;
            stateNext = ST_START;
          end
        end
        ST_START: begin
          if (baudTick) begin
            strobes.sendData = 1'b1;
            bitCntNext = bitsForLen(lenSel) - BIT_CNT_W'(1);
            stateNext = ST_DATA;
          end
        end
        ST_DATA: begin
          if (baudTick) begin
            if (bitCnt != '0) begin
              strobes.sendData = 1'b1;
              bitCntNext = bitCnt - BIT_CNT_W'(1);
            end else if (parityEn) begin
              strobes.sendParity = 1'b1;
              stateNext = ST_PARITY;
            end else begin
              strobes.sendStop = 1'b1;
              stateNext = ST_STOP1;
            end
          end
        end
        ST_PARITY: begin
          if (baudTick) begin
            strobes.sendStop = 1'b1;
            stateNext = ST_STOP1;
          end
        end
        ST_STOP1, ST_STOP2: begin
          if (baudTick) begin
            if (state == ST_STOP1 && twoStop) begin
              strobes.sendStop = 1'b1;
              stateNext = ST_STOP2;
            end else if (holdFull) begin
              // chain the next word straight into a start bit
              strobes.loadShift = 1'b1;
              strobes.sendStart = 1'b1;
              stateNext = ST_START;
            end else begin
              strobes.goIdle = 1'b1;
              stateNext = ST_IDLE;
            end
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !active) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state  <= stateNext;
      bitCnt <= bitCntNext;
    end
  end

  assign shiftIdle = (state == ST_IDLE);

endmodule

// File: rtl/ser_tx_dpath.sv
`timescale 1ns/1ps
module ser_tx_dpath
  import ser_tx_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     active,
  input  logic                     wrEn,
  input  logic [MAX_DATA_BITS-1:0] wrData,
  input  logic [1:0]               lenSel,
  input  txStrobes_t               strobes,
  output logic                     holdFull,
  output logic                     txLine
);

  logic [MAX_DATA_BITS-1:0] holdReg;
  logic [MAX_DATA_BITS-1:0] shiftReg;
  logic [MAX_DATA_BITS-1:0] lenMask;
  logic [MAX_DATA_BITS-1:0] heldBits;
  logic                     parityBit;
  logic                     lineReg;

  always_comb begin
    lenMask  = ~({MAX_DATA_BITS{1'b1}} << bitsForLen(lenSel));
    heldBits = holdReg & lenMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg   <= '0;
      holdFull  <= 1'b0;
      shiftReg  <= '0;
      parityBit <= 1'b0;
      lineReg   <= 1'b1;
    end else if (!active) begin
      holdFull  <= 1'b0;
      lineReg   <= 1'b1;
    end else begin
      if (strobes.loadShift) begin
        shiftReg  <= heldBits;
        parityBit <= ^heldBits;
        holdFull  <= 1'b0;
      end else if (wrEn && !holdFull) begin
        holdReg  <= wrData;
        holdFull <= 1'b1;
      end

      if (strobes.sendStart) begin
        lineReg <= 1'b0;
      end else if (strobes.sendData) begin
        lineReg  <= shiftReg[0];
        shiftReg <= shiftReg >> 1;
      end else if (strobes.sendParity) begin
        lineReg <= parityBit;
      end else if (strobes.sendStop || strobes.goIdle) begin
        lineReg <= 1'b1;
      end
    end
  end

  assign txLine = lineReg;

endmodule

// File: rtl/ser_tx_dbuf.sv
`timescale 1ns/1ps
module ser_tx_dbuf
  import ser_tx_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int NARROW_W   = 8,
  parameter int FAST_SHIFT = 4,
  parameter int SLOW_SHIFT = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     blockEn,
  input  logic                     txEn,
  input  logic                     syncSel,
  input  logic                     hiSpeed,
  input  logic                     wideDiv,
  input  logic [DIV_W-1:0]         divisor,
  input  logic [1:0]               lenSel,
  input  logic                     parityEn,
  input  logic                     twoStop,
  input  logic                     wrEn,
  input  logic [MAX_DATA_BITS-1:0] wrData,
  output logic                     holdEmpty,
  output logic                     shiftEmpty,
  output logic                     txLine
);

  logic       active;
  logic       baudTick;
  logic       holdFull;
  logic       shiftIdle;
  txStrobes_t strobes;

  assign active = blockEn && txEn && !syncSel;

  ser_tx_baud #(
    .DIV_W(DIV_W), .NARROW_W(NARROW_W),
    .FAST_SHIFT(FAST_SHIFT), .SLOW_SHIFT(SLOW_SHIFT)
  ) u_baud (
    .clk(clk), .rstN(rstN), .run(active), .hiSpeed(hiSpeed),
    .wideDiv(wideDiv), .divisor(divisor), .baudTick(baudTick)
  );

  ser_tx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .active(active), .baudTick(baudTick),
    .holdFull(holdFull), .lenSel(lenSel), .parityEn(parityEn),
    .twoStop(twoStop), .strobes(strobes), .shiftIdle(shiftIdle)
  );

  ser_tx_dpath u_dpath (
    .clk(clk), .rstN(rstN), .active(active), .wrEn(wrEn),
    .wrData(wrData), .lenSel(lenSel), .strobes(strobes),
    .holdFull(holdFull), .txLine(txLine)
  );

  assign holdEmpty  = active && !holdFull;
  assign shiftEmpty = shiftIdle;

endmodule

// File: rtl/ser_tx_dbuf_chk.sv
`timescale 1ns/1ps
module ser_tx_dbuf_chk (
  input logic clk,
  input logic rstN,
  input logic blockEn,
  input logic txEn,
  input logic syncSel,
  input logic wrEn,
  input logic holdEmpty,
  input logic shiftEmpty,
  input logic txLine
);

  logic act;
  assign act = blockEn && txEn && !syncSel;

  // R1: an idle shifter never leaves the line low
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rstN)
    shiftEmpty |-> txLine);

  // R4: loading the shifter does not itself drive the start bit
  p_start_waits_tick_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(shiftEmpty) |-> txLine);

  // R4: an accepted write into an empty buffer is visible as a full holding register one cycle later
  p_write_takes_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (act && wrEn && holdEmpty && shiftEmpty) |=> !holdEmpty);

  // R5: the shifter reports empty only after a stop level has been on the line
  p_empty_after_stop_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(shiftEmpty) && act && $past(act)) |-> $past(txLine));

  // R6: an inactive transmitter releases the line and the shifter next cycle
  p_inactive_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !act |=> (txLine && shiftEmpty));

endmodule

bind ser_tx_dbuf ser_tx_dbuf_chk u_chk (
  .clk(clk), .rstN(rstN), .blockEn(blockEn), .txEn(txEn), .syncSel(syncSel),
  .wrEn(wrEn), .holdEmpty(holdEmpty), .shiftEmpty(shiftEmpty), .txLine(txLine)
);

// File: tb/ser_tx_dbuf_bench.sv
`timescale 1ns/1ps
module ser_tx_dbuf_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        blockEn = 1'b1, txEn = 1'b1, syncSel = 1'b0;
  logic        hiSpeed = 1'b1, wideDiv = 1'b0;
  logic [15:0] divisor = 16'h0;
  logic [1:0]  lenSel = 2'd1;
  logic        parityEn = 1'b0, twoStop = 1'b0;
  logic        wrEn = 1'b0;
  logic [8:0]  wrData = 9'h0;
  logic        holdEmpty, shiftEmpty, txLine;

  int nRun = 0;
  int nFail = 0;
  int lastWait = 0;

  always #10 clk = ~clk;

  ser_tx_dbuf u_ser_tx_dbuf (
    .clk(clk), .rstN(rstN), .blockEn(blockEn), .txEn(txEn), .syncSel(syncSel),
    .hiSpeed(hiSpeed), .wideDiv(wideDiv), .divisor(divisor), .lenSel(lenSel),
    .parityEn(parityEn), .twoStop(twoStop), .wrEn(wrEn), .wrData(wrData),
    .holdEmpty(holdEmpty), .shiftEmpty(shiftEmpty), .txLine(txLine)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int bitPeriod();
    int n;
    n = wideDiv ? int'(divisor) : int'(divisor[7:0]);
    return (hiSpeed ? 16 : 64) * (n + 1);
  endfunction

  function automatic int dataBits();
    case (lenSel)
      2'd0: return 7;
      2'd2: return 9;
      default: return 8;
    endcase
  endfunction

  task automatic writeWord(input logic [8:0] d);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Wait for a start bit, check every bit at its midpoint, optionally the exact end of frame
  task automatic expectFrame(input logic [8:0] d, input bit checkEnd);
    int p, nb, total, waited, ones;
    logic expBits [0:13];
    string tagOf [0:13];
    p = bitPeriod();
    nb = dataBits();
    waited = 0;
    ones = 0;
    total = 0;
    expBits[total] = 1'b0; tagOf[total] = "R1 start bit"; total++;
    for (int j = 0; j < nb; j++) begin
      expBits[total] = d[j]; tagOf[total] = "R2 data bit"; total++;
      ones += int'(d[j]);
    end
    if (parityEn) begin
      expBits[total] = ones[0]; tagOf[total] = "R3 parity bit"; total++;
    end
    expBits[total] = 1'b1; tagOf[total] = "R1 stop bit"; total++;
    if (twoStop) begin
      expBits[total] = 1'b1; tagOf[total] = "R1 second stop bit"; total++;
    end
    while (txLine !== 1'b0 && waited < 3 * p + 8) begin
      @(negedge clk);
      waited++;
    end
    lastWait = waited;
    chk(txLine === 1'b0, "R1 start bit seen", longint'(txLine), 0);
    repeat (p / 2) @(negedge clk);
    for (int i = 0; i < total; i++) begin
      chk(txLine === expBits[i], tagOf[i], longint'(txLine), longint'(expBits[i]));
      if (i < total - 1) repeat (p) @(negedge clk);
    end
    if (checkEnd) begin
      repeat (p / 2 - 1) @(negedge clk);
      chk(shiftEmpty === 1'b0, "R5 R7 busy until last clock of frame", longint'(shiftEmpty), 0);
      @(negedge clk);
      chk(shiftEmpty === 1'b1, "R5 R7 empty exactly at frame end", longint'(shiftEmpty), 1);
    end
  endtask

  // Single word into an idle transmitter: flag timing then frame contents
  task automatic singleWord(input logic [8:0] d);
    writeWord(d);
    chk(holdEmpty === 1'b0, "R4 hold full after write", longint'(holdEmpty), 0);
    @(negedge clk);
    chk(holdEmpty === 1'b1 && shiftEmpty === 1'b0, "R4 moved to shifter",
        longint'({holdEmpty, shiftEmpty}), 2);
    expectFrame(d, 1'b1);
    chk(lastWait <= bitPeriod(), "R4 start within one bit period", lastWait, bitPeriod());
  endtask

  initial begin
    logic [8:0] pats [0:3];
    bit stayedHigh;
    pats[0] = 9'h000; pats[1] = 9'h1FF; pats[2] = 9'h0A5; pats[3] = 9'h13C;

    // R9: reset state
    repeat (3) @(negedge clk);
    chk(txLine === 1'b1, "R9 line high in reset", longint'(txLine), 1);
    chk(shiftEmpty === 1'b1, "R9 shifter empty in reset", longint'(shiftEmpty), 1);
    rstN = 1'b1;
    @(negedge clk);
    chk(txLine === 1'b1 && shiftEmpty === 1'b1, "R9 idle after reset",
        longint'({txLine, shiftEmpty}), 3);
    chk(holdEmpty === 1'b1, "R6 hold empty once enabled", longint'(holdEmpty), 1);

    // Sweep every frame shape at a 16-clock bit period
    hiSpeed = 1'b1; wideDiv = 1'b0; divisor = 16'h0000;
    for (int l = 0; l < 4; l++) begin
      for (int pe = 0; pe < 2; pe++) begin
        for (int ts = 0; ts < 2; ts++) begin
          for (int k = 0; k < 4; k++) begin
            lenSel = 2'(l); parityEn = pe[0]; twoStop = ts[0];
            singleWord(pats[k]);
          end
        end
      end
    end

    // R7: divisor and prescale variants
    lenSel = 2'd1; parityEn = 1'b0; twoStop = 1'b0;
    divisor = 16'h0101; wideDiv = 1'b0; hiSpeed = 1'b1;
    singleWord(9'h055);
    hiSpeed = 1'b0;
    singleWord(9'h0C3);
    lenSel = 2'd0; hiSpeed = 1'b1; wideDiv = 1'b1;
    singleWord(9'h06A);
    lenSel = 2'd1; wideDiv = 1'b0; divisor = 16'h0000;

    // R5 and R8: back-to-back words, third write while full is dropped
    writeWord(9'h0E1);
    @(negedge clk);
    writeWord(9'h03C);
    chk(holdEmpty === 1'b0, "R8 hold full with second word", longint'(holdEmpty), 0);
    writeWord(9'h0FF);
    chk(holdEmpty === 1'b0, "R8 write while full leaves flag low", longint'(holdEmpty), 0);
    expectFrame(9'h0E1, 1'b0);
    repeat (bitPeriod() / 2 - 1) @(negedge clk);
    chk(holdEmpty === 1'b0 && shiftEmpty === 1'b0 && txLine === 1'b1,
        "R5 last stop of first frame", longint'({holdEmpty, shiftEmpty, txLine}), 1);
    @(negedge clk);
    chk(holdEmpty === 1'b1, "R5 held word taken at frame end", longint'(holdEmpty), 1);
    chk(txLine === 1'b0 && shiftEmpty === 1'b0, "R5 start follows without gap",
        longint'({txLine, shiftEmpty}), 0);
    expectFrame(9'h03C, 1'b1);
    chk(lastWait == 0, "R5 no idle time between frames", lastWait, 0);
    stayedHigh = 1'b1;
    repeat (3 * bitPeriod()) begin
      @(negedge clk);
      if (txLine !== 1'b1 || shiftEmpty !== 1'b1) stayedHigh = 1'b0;
    end
    chk(stayedHigh, "R8 dropped word never sent", longint'(stayedHigh), 1);

    // R6: writes while inactive are dropped
    @(negedge clk);
    txEn = 1'b0;
    #1;
    chk(holdEmpty === 1'b0, "R6 hold flag low when disabled", longint'(holdEmpty), 0);
    writeWord(9'h0AA);
    txEn = 1'b1;
    #1;
    chk(holdEmpty === 1'b1, "R6 hold flag set on enable", longint'(holdEmpty), 1);
    stayedHigh = 1'b1;
    repeat (3 * bitPeriod()) begin
      @(negedge clk);
      if (txLine !== 1'b1 || shiftEmpty !== 1'b1) stayedHigh = 1'b0;
    end
    chk(stayedHigh, "R6 write while disabled ignored", longint'(stayedHigh), 1);
    syncSel = 1'b1;
    #1;
    chk(holdEmpty === 1'b0, "R6 sync select blocks transmitter", longint'(holdEmpty), 0);
    syncSel = 1'b0;

    // R6: dropping the module enable abandons a frame
    writeWord(9'h000);
    repeat (4 * bitPeriod()) @(negedge clk);
    chk(txLine === 1'b0 && shiftEmpty === 1'b0, "R6 frame in progress",
        longint'({txLine, shiftEmpty}), 0);
    blockEn = 1'b0;
    @(negedge clk);
    chk(txLine === 1'b1 && shiftEmpty === 1'b1 && holdEmpty === 1'b0, "R6 abort on disable",
        longint'({txLine, shiftEmpty, holdEmpty}), 6);
    blockEn = 1'b1;
    @(negedge clk);
    singleWord(9'h05A);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule